// File: doc/BRIEF.md
# GPIO Port Interrupt Router

This block serves a group of general-purpose pins organised into ports. For every pin, software chooses whether the block drives it and what value it drives, and it can read back the pin level after synchronisation. Each pin also has an event detector. A 4-bit code programs the detector to catch rising edges, falling edges, both edges, a high level or a low level. The detector decodes the code into one of three modes. MODE_OFF is used for code 0 and every other code that is not legal. MODE_EDGE is used for codes 1, 2 and 3. MODE_LEVEL is used for codes 4 and 8. A pin moves between modes only when its trigger code is rewritten. In MODE_OFF the status is held at 0. In MODE_EDGE a detected edge sets the status, and the status stays set until it is cleared. In MODE_LEVEL the status tracks the pin level.

Each pin has a route field that sends its status to one of several interrupt lines, so different processors can own different pins. Each line has its own status register per port and its own registered interrupt output. A line's output is high when any enabled pin routed to it has status set. The register port is a plain write strobe and a read strobe. The upper address bits select an alias, and the block ignores them, so every alias reaches the same registers.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, all registers read 0, and `pin_oe`, `pin_out` and `irq` are 0. Every pin starts as an input, disabled, with trigger code 0, routed to line 0.
- R2: Offset 0 holds the direction bits, one bit per pin, where 1 means drive. Offset 1 holds the output values. `pin_oe` and `pin_out` follow these registers one cycle after the write.
- R3: Offset 2 is read-only. It returns the pin levels after a two-flop synchroniser.
- R4: The address is {alias[1:0], port[0], offset[2:0]}. The alias field is ignored, so a write through any alias is read back identically through every other alias.
- R5: At offset 3, pin p's trigger code sits in bits [4p+3:4p]. Code 1 sets the pin's status on a synchronised 0-to-1 change, and the status stays set.
- R6: Code 2 sets the status on a 1-to-0 change. Code 3 sets it on either change. In both cases the status stays set.
- R7: Code 4 makes the status equal the synchronised level, and code 8 makes it equal the inverted level. Writing 1 to clear does not change a level status.
- R8: Any code other than 1, 2, 3, 4 and 8 leaves the status at 0.
- R9: Offset 6+k is the status register of line k. Bit p reads pin p's status when the pin is enabled and routed to line k. Writing 1 to bit p clears pin p's edge status only if pin p is routed to line k. Writing 0 has no effect.
- R10: At offset 4, bit p selects pin p's line. `irq[k]` rises only for pins routed to line k.
- R11: Offset 5 holds the enable bits. A disabled pin never sets its status, is masked from the status registers, and does not drive `irq`.
- R12: A pin edge at the input shows on `irq` after four rising clock edges: two synchroniser stages, the status flop and the output flop. `irq` falls one edge after the clearing write has taken effect.
- R13: The port field selects independent register sets for each port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; `rd_data` updates on the next edge |
| addr | input | 6 | {alias, port, offset} |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| pin_in | input | 8 | Pin levels, asynchronous |
| pin_out | output | 8 | Driven pin values |
| pin_oe | output | 8 | Drive enables |
| irq | output | 2 | One interrupt output per line |

## Verification
The bench sweeps all sixteen trigger codes through a rise and a fall, each followed by a clear. A design that decoded an illegal code as an edge mode, or that let a clear remove a level status, would show the wrong status bit at once. The bench routes pins on one port to both lines and clears through one line's register. A design that cleared regardless of the route would lose the pins on the other line. The bench also disables a pin that has sticky status, which catches a design that leaks masked status onto `irq`. It counts cycles exactly on the edge-to-`irq` path, which catches a missing or extra pipeline stage.

// File: rtl/gpir_pkg.sv
package gpir_pkg;
    localparam int TRIG_W = 4;

    typedef enum logic [3:0] {
        TRIG_NONE = 4'd0,
        TRIG_RISE = 4'd1,
        TRIG_FALL = 4'd2,
        TRIG_BOTH = 4'd3,
        TRIG_HIGH = 4'd4,
        TRIG_LOW  = 4'd8
    } trig_code_e;

    typedef enum logic [1:0] {
        MODE_OFF,
        MODE_EDGE,
        MODE_LEVEL
    } det_mode_e;

    localparam int OFF_DIR   = 0;
    localparam int OFF_OUT   = 1;
    localparam int OFF_IN    = 2;
    localparam int OFF_TRIG  = 3;
    localparam int OFF_ROUTE = 4;
    localparam int OFF_EN    = 5;
    localparam int OFF_STAT0 = 6;
endpackage

// File: rtl/gpir_sync.sv
module gpir_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q, stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/gpir_pin_detect.sv
module gpir_pin_detect
    import gpir_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    input  logic [TRIG_W-1:0] trig,
    input  logic              en,
    input  logic              clr,
    output logic              status
);
    logic      prev_q, status_q, status_d, hit;
    det_mode_e mode;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // Decode the trigger code into a detector mode and a hit condition.
    always_comb begin
        mode = MODE_OFF;
        hit  = 1'b0;
        unique case (trig)
            TRIG_RISE: begin mode = MODE_EDGE;  hit = lvl & ~prev_q; end
            TRIG_FALL: begin mode = MODE_EDGE;  hit = ~lvl & prev_q; end
            TRIG_BOTH: begin mode = MODE_EDGE;  hit = lvl ^ prev_q;  end
            TRIG_HIGH: begin mode = MODE_LEVEL; hit = lvl;           end
            TRIG_LOW:  begin mode = MODE_LEVEL; hit = ~lvl;          end
            default:   begin mode = MODE_OFF;   hit = 1'b0;          end
        endcase
    end

    always_comb begin
        unique case (mode)
            MODE_EDGE:  status_d = (status_q & ~clr) | (en & hit);
            MODE_LEVEL: status_d = en & hit;
            default:    status_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= 1'b0;
        else        status_q <= status_d;
    end

    assign status = status_q;

    assert_edge_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_EDGE && status_q && !clr) |=> status_q);
    assert_level_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LEVEL && en && hit) |=> status_q);
    assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |=> !status_q);
    assert_disabled_no_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !status_q) |=> !status_q);
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gpir_pkg::*;
#(
    parameter int PINS_PER_PORT = 4,
    parameter int NUM_PORTS     = 2,
    parameter int NUM_LINES     = 2,
    parameter int NUM_ALIASES   = 4,
    localparam int NPINS   = PINS_PER_PORT * NUM_PORTS,
    localparam int DW      = PINS_PER_PORT * TRIG_W,
    localparam int LSEL_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int PORT_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int ALIAS_W = (NUM_ALIASES > 1) ? $clog2(NUM_ALIASES) : 1,
    localparam int OFF_W   = $clog2(OFF_STAT0 + NUM_LINES),
    localparam int ADDR_W  = ALIAS_W + PORT_W + OFF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rd_data,
    input  logic [NPINS-1:0]     pin_in,
    output logic [NPINS-1:0]     pin_out,
    output logic [NPINS-1:0]     pin_oe,
    output logic [NUM_LINES-1:0] irq
);
    localparam int P = PINS_PER_PORT;

    logic [OFF_W-1:0]   off;
    logic [PORT_W-1:0]  psel;
    logic [ALIAS_W-1:0] alias_bits_unused;
    logic               port_ok;

    assign off               = addr[OFF_W-1:0];
    assign psel              = addr[OFF_W +: PORT_W];
    assign alias_bits_unused = addr[ADDR_W-1 -: ALIAS_W];  // every alias maps to the same state
    assign port_ok           = ({1'b0, psel} < (PORT_W+1)'(NUM_PORTS));

    logic [P-1:0]        dir_q   [NUM_PORTS];
    logic [P-1:0]        out_q   [NUM_PORTS];
    logic [P-1:0]        en_q    [NUM_PORTS];
    logic [DW-1:0]       trig_q  [NUM_PORTS];
    logic [P*LSEL_W-1:0] route_q [NUM_PORTS];

    logic [NPINS-1:0]                pin_sync, stat_all;
    logic [NUM_LINES-1:0][NPINS-1:0] line_hit;
    logic [DW-1:0]                   rd_d, rd_q;
    logic [NUM_LINES-1:0]            irq_q;

    gpir_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        logic wr_here;
        assign wr_here = wr_en && port_ok && (psel == PORT_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dir_q[g]   <= '0;
                out_q[g]   <= '0;
                en_q[g]    <= '0;
                trig_q[g]  <= '0;
                route_q[g] <= '0;
            end else if (wr_here) begin
                if (off == OFF_W'(OFF_DIR))   dir_q[g]   <= wdata[P-1:0];
                if (off == OFF_W'(OFF_OUT))   out_q[g]   <= wdata[P-1:0];
                if (off == OFF_W'(OFF_EN))    en_q[g]    <= wdata[P-1:0];
                if (off == OFF_W'(OFF_TRIG))  trig_q[g]  <= wdata;
                if (off == OFF_W'(OFF_ROUTE)) route_q[g] <= wdata[P*LSEL_W-1:0];
            end
        end

        assign pin_oe[g*P +: P]  = dir_q[g];
        assign pin_out[g*P +: P] = out_q[g];

        for (genvar p = 0; p < P; p++) begin : g_pin
            localparam int IDX = g*P + p;
            logic [LSEL_W-1:0] rsel;
            logic              clr_p;

            assign rsel  = route_q[g][p*LSEL_W +: LSEL_W];
            // A clear only reaches the pin through its own line's status register.
            assign clr_p = wr_here && wdata[p] &&
                           (off == OFF_W'(OFF_STAT0) + OFF_W'(rsel));

            gpir_pin_detect u_det (
                .clk(clk), .rst_n(rst_n), .lvl(pin_sync[IDX]),
                .trig(trig_q[g][p*TRIG_W +: TRIG_W]), .en(en_q[g][p]),
                .clr(clr_p), .status(stat_all[IDX])
            );

            for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
                assign line_hit[k][IDX] = stat_all[IDX] & en_q[g][p] &
                                          (rsel == LSEL_W'(k));
            end
        end
    end

    always_comb begin
        rd_d = '0;
        if (port_ok) begin
            if (off == OFF_W'(OFF_DIR))   rd_d[P-1:0]        = dir_q[psel];
            if (off == OFF_W'(OFF_OUT))   rd_d[P-1:0]        = out_q[psel];
            if (off == OFF_W'(OFF_IN))    rd_d[P-1:0]        = pin_sync[psel*P +: P];
            if (off == OFF_W'(OFF_TRIG))  rd_d               = trig_q[psel];
            if (off == OFF_W'(OFF_ROUTE)) rd_d[P*LSEL_W-1:0] = route_q[psel];
            if (off == OFF_W'(OFF_EN))    rd_d[P-1:0]        = en_q[psel];
            for (int k = 0; k < NUM_LINES; k++) begin
                if (off == OFF_W'(OFF_STAT0 + k)) rd_d[P-1:0] = line_hit[k][psel*P +: P];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= rd_d;
    end
    assign rd_data = rd_q;

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_irq
        always_ff @(posedge clk) begin
            if (!rst_n) irq_q[k] <= 1'b0;
            else        irq_q[k] <= |line_hit[k];
        end

        assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (line_hit[k] == '0) |=> !irq_q[k]);
        assert_irq_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (line_hit[k] != '0) |=> irq_q[k]);
    end
    assign irq = irq_q;

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && psel == '0 && off == OFF_W'(OFF_DIR)) |=>
        (pin_oe[P-1:0] == $past(wdata[P-1:0])));
endmodule

// File: tb/gpio_irq_router_test.sv
`timescale 1ns/1ps
module gpio_irq_router_test;
    localparam int OFF_DIR = 0, OFF_OUT = 1, OFF_IN = 2, OFF_TRIG = 3;
    localparam int OFF_ROUTE = 4, OFF_EN = 5, OFF_ST0 = 6, OFF_ST1 = 7;

    logic        clk = 1'b0;
    logic        rst_n, wr_en, rd_en;
    logic [5:0]  addr;
    logic [15:0] wdata, rd_data;
    logic [7:0]  pin_in, pin_out, pin_oe;
    logic [1:0]  irq;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    gpio_irq_router uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [5:0] mk(int al, int port, int off);
        return {2'(al), 1'(port), 3'(off)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [15:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] d;
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; pin_in = '0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 pin_out", pin_out, 0);
        chk("R1 irq", irq, 0);
        for (int port = 0; port < 2; port++)
            for (int o = 0; o < 8; o++) begin
                rd(mk(0, port, o), d);
                chk("R1 register", d, 0);
            end

        // R2 / R13 / R4: direction and output per port and alias
        wr(mk(0, 0, OFF_DIR), 16'h9);
        chk("R2 pin_oe", pin_oe, 8'h09);
        rd(mk(1, 0, OFF_DIR), d); chk("R2 dir read", d, 16'h9);
        wr(mk(0, 0, OFF_OUT), 16'h6);
        chk("R2 pin_out", pin_out, 8'h06);
        wr(mk(2, 1, OFF_DIR), 16'h6);
        chk("R13 pin_oe both ports", pin_oe, 8'h69);
        rd(mk(0, 0, OFF_DIR), d); chk("R13 port0 dir kept", d, 16'h9);
        wr(mk(3, 1, OFF_OUT), 16'hC);
        for (int al = 0; al < 4; al++) begin
            rd(mk(al, 1, OFF_OUT), d); chk("R4 alias read", d, 16'hC);
        end
        chk("R4 pin_out", pin_out, 8'hC6);

        // R3: synchronised input sweep over all pin patterns
        for (int v = 0; v < 256; v++) begin
            pin_in = 8'(v);
            idle(3);
            rd(mk(v % 4, 0, OFF_IN), d); chk("R3 port0 input", d, 16'(v & 15));
            rd(mk(v % 4, 1, OFF_IN), d); chk("R3 port1 input", d, 16'(v >> 4));
        end
        pin_in = '0;
        idle(4);

        // R5..R9: every trigger code on port0 pin0
        wr(mk(0, 0, OFF_EN), 16'h1);
        wr(mk(0, 0, OFF_ROUTE), 16'h0);
        for (int c = 0; c < 16; c++) begin
            string tag;
            bit    ex_rise, ex_fall;
            tag = (c == 1) ? "R5" : (c == 2 || c == 3) ? "R6" :
                  (c == 4 || c == 8) ? "R7" : "R8";
            ex_rise = (c == 1 || c == 3 || c == 4);
            ex_fall = (c == 2 || c == 3 || c == 8);
            pin_in[0] = 1'b0;
            idle(4);
            wr(mk(0, 0, OFF_TRIG), 16'(c));
            wr(mk(0, 0, OFF_ST0), 16'h1);
            idle(2);
            pin_in[0] = 1'b1;
            idle(5);
            rd(mk(0, 0, OFF_ST0), d); chk({tag, " after rise"}, d, 16'(ex_rise));
            wr(mk(0, 0, OFF_ST0), 16'h1);
            rd(mk(0, 0, OFF_ST0), d); chk("R9 clear after rise", d, 16'(c == 4));
            pin_in[0] = 1'b0;
            idle(5);
            rd(mk(0, 0, OFF_ST0), d); chk({tag, " after fall"}, d, 16'(ex_fall));
            wr(mk(1, 0, OFF_ST0), 16'h1);
            rd(mk(0, 0, OFF_ST0), d); chk("R9 clear after fall", d, 16'(c == 8));
        end

        // R12: exact edge-to-irq latency and clear-to-drop latency
        wr(mk(0, 0, OFF_TRIG), 16'h1);
        wr(mk(0, 0, OFF_ST0), 16'h1);
        idle(2);
        chk("R12 irq idle", irq, 2'b00);
        @(negedge clk); pin_in[0] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); chk("R12 irq not yet", irq, 2'b00);
        @(negedge clk); chk("R12 irq on fourth edge", irq, 2'b01);
        wr(mk(0, 0, OFF_ST0), 16'h1);
        chk("R12 irq one edge after clear", irq, 2'b01);
        @(negedge clk); chk("R12 irq dropped", irq, 2'b00);
        pin_in[0] = 1'b0;
        wr(mk(0, 0, OFF_EN), 16'h0);

        // R10 / R9 / R11: routing on port1, both-edge trigger
        wr(mk(0, 1, OFF_TRIG), 16'h3333);
        wr(mk(0, 1, OFF_ROUTE), 16'hA);
        wr(mk(0, 1, OFF_EN), 16'hF);
        idle(4);
        pin_in[7:4] = 4'hF;
        idle(6);
        rd(mk(0, 1, OFF_ST0), d); chk("R10 line0 status", d, 16'h5);
        rd(mk(0, 1, OFF_ST1), d); chk("R10 line1 status", d, 16'hA);
        chk("R10 both lines", irq, 2'b11);
        wr(mk(2, 1, OFF_ST0), 16'hF);
        rd(mk(0, 1, OFF_ST0), d); chk("R9 line0 cleared", d, 16'h0);
        rd(mk(0, 1, OFF_ST1), d); chk("R9 other line kept", d, 16'hA);
        chk("R10 only line1", irq, 2'b10);
        wr(mk(0, 1, OFF_ST1), 16'h2);
        rd(mk(0, 1, OFF_ST1), d); chk("R9 partial clear", d, 16'h8);
        wr(mk(0, 1, OFF_EN), 16'h7);
        rd(mk(0, 1, OFF_ST1), d); chk("R11 masked status", d, 16'h0);
        idle(2);
        chk("R11 irq masked", irq, 2'b00);
        wr(mk(0, 1, OFF_EN), 16'hF);
        rd(mk(0, 1, OFF_ST1), d); chk("R11 sticky under mask", d, 16'h8);
        wr(mk(0, 1, OFF_ST1), 16'h8);
        wr(mk(0, 1, OFF_EN), 16'h7);
        pin_in[7] = 1'b0;
        idle(6);
        wr(mk(0, 1, OFF_EN), 16'hF);
        rd(mk(0, 1, OFF_ST1), d); chk("R11 no set while disabled", d, 16'h0);
        idle(2);
        chk("R11 irq quiet", irq, 2'b00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule